// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This block sits between a 32-bit execution datapath and a data memory that is organized in words. For each request it takes an operation code, a base register value, a signed 16-bit displacement and store data. From these it forms the byte effective address and drives a word address, per-byte write enables and lane-aligned write data toward the memory. On loads it captures the returned word and delivers the result one cycle later: either the whole word, or a single byte sign-extended to 32 bits.

Byte numbering inside a word is chosen per request by an input. In little-endian mode the byte at address offset 0 of a word lives in bits [7:0]. In big-endian mode that byte lives in bits [31:24]. A byte written and then read back at the same address returns the same value in either mode. The difference shows only when a word is written and its bytes are then read one at a time.

The memory read path is treated as combinational from `mem_addr` to `mem_rdata` within the request cycle. The unit itself supplies the one-cycle register that gives a synchronous-memory load latency.

Top module: `lsu_lane`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended to 32 bits, modulo 2^32. `mem_addr` carries bits [31:2] of it during every request.
- R2: A byte store (opcode 0x28) asserts `mem_wr` and exactly one bit of `mem_wben`. Bit i of `mem_wben` enables data bits [8i+7:8i]. The bit chosen is address bits [1:0] in little-endian mode (`big_end`=0) and 3 minus address bits [1:0] in big-endian mode (`big_end`=1).
- R3: During a byte store, `mem_wdata` holds `wdata[7:0]` in all four byte lanes.
- R4: A word store (opcode 0x2b) asserts `mem_wr` and `mem_wben`=4'hF and passes `wdata` through unchanged. Address bits [1:0] do not change the word address, the enables or the data.
- R5: `misalign` is 1 only during a word load (0x23) or word store whose effective address has nonzero bits [1:0]. It is 0 for byte accesses and when no request is present.
- R6: A load request (0x20 or 0x23) raises `load_valid` for exactly the following cycle, with `load_data` valid in that cycle. Lane selection uses the address and mode captured with the request. `load_data` holds its value until the next load completes.
- R7: A byte load (0x20) returns the byte in the addressed lane, chosen with the R2 mapping, sign-extended to 32 bits.
- R8: A word load (0x23) returns the whole word at `mem_addr`, whatever address bits [1:0] are.
- R9: Any other opcode, or `req_valid`=0, leaves `mem_wr`, `mem_rd` and `mem_wben` at 0 and produces no `load_valid`.
- R10: After reset, `load_valid` is 0 and `load_data` is 0.
- R11: Storing byte 5 at address 2 and loading byte 2 returns 5 in both modes. After a word store of 0x00000005 at address 8, a byte load at 8 returns 5 in little-endian mode and 0 in big-endian mode, and a byte load at 11 returns 5 in big-endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| opcode | input | 6 | Operation: 0x20 byte load, 0x23 word load, 0x28 byte store, 0x2b word store |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| wdata | input | 32 | Store data (byte stores use bits [7:0]) |
| big_end | input | 1 | 1 selects big-endian byte numbering |
| mem_addr | output | 30 | Word address to memory |
| mem_rd | output | 1 | Load access this cycle |
| mem_wr | output | 1 | Store access this cycle |
| mem_wben | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-aligned store data |
| mem_rdata | input | 32 | Word read from memory at `mem_addr` |
| misalign | output | 1 | Word access with nonzero low address bits |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Load result |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath, a 32-bit address and a 16-bit displacement. With these widths the sign-extension of negative displacements and of bytes with bit 7 set are exercised on the real 32-bit result. A 64-byte window of the memory model keeps random byte stores and loads colliding on the same words, so the lane mapping is checked against earlier writes in both byte orders. Random traffic also switches `big_end` between requests, which puts the capture of the mode with the request within reach.

// File: rtl/lsu_lane.sv
module lsu_lane #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16,
  localparam int NB = DW / 8,
  localparam int LW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [5:0]    opcode,
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] offset,
  input  logic [DW-1:0] wdata,
  input  logic          big_end,
  output logic [AW-LW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [NB-1:0] mem_wben,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          misalign,
  output logic          load_valid,
  output logic [DW-1:0] load_data
);
  localparam logic [5:0] OP_LB = 6'h20;
  localparam logic [5:0] OP_LW = 6'h23;
  localparam logic [5:0] OP_SB = 6'h28;
  localparam logic [5:0] OP_SW = 6'h2b;

  logic [AW-1:0] ea;
  logic [LW-1:0] lane;
  logic is_lb, is_lw, is_sb, is_sw;

  assign ea    = base + {{(AW-OW){offset[OW-1]}}, offset};
  assign lane  = big_end ? (LW'(NB-1) - ea[LW-1:0]) : ea[LW-1:0];
  assign is_lb = req_valid && opcode == OP_LB;
  assign is_lw = req_valid && opcode == OP_LW;
  assign is_sb = req_valid && opcode == OP_SB;
  assign is_sw = req_valid && opcode == OP_SW;

  assign mem_addr  = ea[AW-1:LW];
  assign mem_rd    = is_lb | is_lw;
  assign mem_wr    = is_sb | is_sw;
  assign mem_wben  = is_sw ? {NB{1'b1}} : (is_sb ? (NB'(1) << lane) : '0);
  assign mem_wdata = is_sb ? {NB{wdata[7:0]}} : wdata;
  assign misalign  = (is_lw | is_sw) && (ea[LW-1:0] != '0);

  logic [DW-1:0] cap_word;
  logic [LW-1:0] cap_lane;
  logic          cap_byte;
  logic [7:0]    sel_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_valid <= 1'b0;
      cap_word   <= '0;
      cap_lane   <= '0;
      cap_byte   <= 1'b0;
    end else begin
      load_valid <= mem_rd;
      if (mem_rd) begin
        cap_word <= mem_rdata;
        cap_lane <= lane;
        cap_byte <= is_lb;
      end
    end
  end

  assign sel_byte  = cap_word[cap_lane*8 +: 8];
  assign load_data = cap_byte ? {{(DW-8){sel_byte[7]}}, sel_byte} : cap_word;
endmodule

// File: rtl/lsu_lane_chk.sv
module lsu_lane_chk #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [5:0]    opcode,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [NB-1:0] mem_wben,
  input logic [DW-1:0] mem_wdata,
  input logic          misalign,
  input logic          load_valid
);
  // R2
  sb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == 6'h28) |-> (mem_wr && $countones(mem_wben) == 1));
  // R3
  sb_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == 6'h28) |-> (mem_wdata[7:0] == mem_wdata[DW-1:DW-8]));
  // R4
  sw_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode == 6'h2b) |-> (mem_wr && mem_wben == {NB{1'b1}}));
  // R5
  misalign_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (req_valid && (opcode == 6'h23 || opcode == 6'h2b)));
  // R6
  load_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> load_valid);
  // R6
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |=> !load_valid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_wr && !mem_rd && mem_wben == '0));
endmodule

bind lsu_lane lsu_lane_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wben(mem_wben),
  .mem_wdata(mem_wdata), .misalign(misalign), .load_valid(load_valid)
);

// File: tb/lsu_lane_tb.sv
module lsu_lane_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  opcode = 6'h0;
  logic [31:0] base = '0;
  logic [15:0] offset = '0;
  logic [31:0] wdata = '0;
  logic        big_end = 1'b0;
  logic [29:0] mem_addr;
  logic        mem_rd, mem_wr, misalign, load_valid;
  logic [3:0]  mem_wben;
  logic [31:0] mem_wdata, mem_rdata, load_data;

  logic [31:0] mem   [16];
  logic [31:0] ref_w [16];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
    .base(base), .offset(offset), .wdata(wdata), .big_end(big_end),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wben(mem_wben), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .misalign(misalign), .load_valid(load_valid), .load_data(load_data)
  );

  assign mem_rdata = mem[mem_addr[3:0]];

  always @(posedge clk)
    if (mem_wr)
      for (int i = 0; i < 4; i++)
        if (mem_wben[i]) mem[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] lane_of(input logic [31:0] ea, input logic be);
    return be ? 2'd3 - ea[1:0] : ea[1:0];
  endfunction

  task automatic do_op(input logic [5:0] op, input logic [31:0] b, input logic [15:0] off,
                       input logic [31:0] wd, input logic be, output logic [31:0] got);
    logic [31:0] ea, exp_ld;
    logic [1:0]  ln;
    logic        is_load, is_known;
    ea = b + {{16{off[15]}}, off};
    ln = lane_of(ea, be);
    is_load  = (op == 6'h20) || (op == 6'h23);
    is_known = is_load || (op == 6'h28) || (op == 6'h2b);
    @(negedge clk);
    req_valid = 1'b1; opcode = op; base = b; offset = off; wdata = wd; big_end = be;
    #1;
    chk({2'b0, mem_addr}, {2'b0, ea[31:2]}, "R1");
    case (op)
      6'h28: begin
        chk({31'b0, mem_wr}, 32'd1, "R2");
        chk({28'b0, mem_wben}, 32'(4'b0001 << ln), "R2");
        chk(mem_wdata, {4{wd[7:0]}}, "R3");
        chk({31'b0, misalign}, 32'd0, "R5");
        ref_w[ea[5:2]][8*ln +: 8] = wd[7:0];
      end
      6'h2b: begin
        chk({31'b0, mem_wr}, 32'd1, "R4");
        chk({28'b0, mem_wben}, 32'hF, "R4");
        chk(mem_wdata, wd, "R4");
        chk({31'b0, misalign}, {31'b0, ea[1:0] != 2'b0}, "R5");
        ref_w[ea[5:2]] = wd;
      end
      6'h23: chk({31'b0, misalign}, {31'b0, ea[1:0] != 2'b0}, "R5");
      6'h20: chk({31'b0, misalign}, 32'd0, "R5");
      default: begin
        chk({31'b0, mem_wr | mem_rd}, 32'd0, "R9");
        chk({28'b0, mem_wben}, 32'd0, "R9");
        chk({31'b0, misalign}, 32'd0, "R5");
      end
    endcase
    if (op == 6'h20) begin
      exp_ld = ref_w[ea[5:2]] >> (8*ln);
      exp_ld = {{24{exp_ld[7]}}, exp_ld[7:0]};
    end else exp_ld = ref_w[ea[5:2]];
    @(negedge clk);
    req_valid = 1'b0;
    opcode = 6'h0;
    big_end = ~be;
    #1;
    got = load_data;
    if (is_load) begin
      chk({31'b0, load_valid}, 32'd1, "R6");
      chk(load_data, exp_ld, op == 6'h20 ? "R7" : "R8");
    end else chk({31'b0, load_valid}, 32'd0, is_known ? "R6" : "R9");
  endtask

  initial begin
    logic [31:0] got;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin mem[i] = '0; ref_w[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R10
    chk({31'b0, load_valid}, 32'd0, "R10");
    chk(load_data, 32'd0, "R10");
    @(negedge clk); rst_n = 1'b1;

    // R11 directed examples
    do_op(6'h28, 32'd0, 16'd2, 32'd5, 1'b0, got);
    do_op(6'h20, 32'd0, 16'd2, 32'd0, 1'b0, got); chk(got, 32'd5, "R11");
    do_op(6'h28, 32'd0, 16'd2, 32'd5, 1'b1, got);
    do_op(6'h20, 32'd0, 16'd2, 32'd0, 1'b1, got); chk(got, 32'd5, "R11");
    do_op(6'h2b, 32'd0, 16'd8, 32'd5, 1'b0, got);
    do_op(6'h20, 32'd0, 16'd8, 32'd0, 1'b0, got); chk(got, 32'd5, "R11");
    do_op(6'h20, 32'd0, 16'd8, 32'd0, 1'b1, got); chk(got, 32'd0, "R11");
    do_op(6'h20, 32'd0, 16'd11, 32'd0, 1'b1, got); chk(got, 32'd5, "R11");
    // R7 sign extension, R1 negative displacement
    do_op(6'h28, 32'h20, 16'hFFFC, 32'h80, 1'b0, got);
    do_op(6'h20, 32'h1C, 16'h0, 32'd0, 1'b0, got); chk(got, 32'hFFFFFF80, "R7");
    // R4 / R5 / R8 misaligned word access uses the enclosing word
    do_op(6'h2b, 32'd9, 16'd0, 32'hCAFE0123, 1'b1, got);
    do_op(6'h23, 32'd10, 16'd0, 32'd0, 1'b0, got); chk(got, 32'hCAFE0123, "R8");
    // R9 unknown opcode
    do_op(6'h24, 32'd4, 16'd0, 32'hFFFFFFFF, 1'b0, got);
    do_op(6'h23, 32'd4, 16'd0, 32'd0, 1'b0, got); chk(got, 32'd0, "R9");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ea, b;
      logic [15:0] off;
      logic [5:0]  op;
      int k;
      ea  = $urandom_range(0, 63);
      off = 16'($signed($urandom_range(0, 400)) - 200);
      b   = ea - {{16{off[15]}}, off};
      k   = $urandom_range(0, 8);
      op  = (k < 2) ? 6'h20 : (k < 4) ? 6'h23 : (k < 6) ? 6'h28 : (k < 8) ? 6'h2b : 6'h0;
      do_op(op, b, off, $urandom, 1'($urandom_range(0, 1)), got);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule